// File: doc/BRIEF.md
# Frequency Sweep Tuning-Word Generator

The block generates the tuning word of a phase-accumulator synthesizer and moves it between a lower and an upper frequency. An external trigger sets the direction. A rising edge on the trigger moves the word up toward the upper frequency. A falling edge moves it back down toward the lower frequency. Each direction has its own step size and its own dwell time per step. The dwell is given in units of four clock cycles. The unit count is clamped to a hardware ceiling, so the longest dwell is 1020 cycles; a request above the ceiling is not rejected.

A mode input selects "ramp up, drop down". In that mode the upward direction still moves in steps, but the downward direction lands on the lower frequency in a single step. A small oscillator is included so the sweep can be observed. It has a phase accumulator that adds the tuning word on every clock and a quantised sine table addressed by the top phase bits. The sweep time is the number of steps times the dwell. The number of steps is the span divided by the step size, rounded up, because the last step stops exactly on the terminal word.

Top module: `chirp_sweeper`

## Requirements
- R1: While `rst` is high, and after it falls until other inputs act, `ftw_out`, `sweeping`, `sweep_done` and `sine_out` are all zero.
- R2: While `sweep_en` is low, `ftw_out` takes the value of `lo_ftw` one clock later, `sweeping` is low and trigger edges are ignored.
- R3: A rising edge of `trig_in` is taken through a two-flop synchroniser. When the block is idle, it loads `lo_ftw` and starts an upward sweep that adds `up_step` once per dwell.
- R4: A falling edge of `trig_in` with `drop_mode` low starts a downward sweep from the current word that subtracts `dn_step` once per dwell.
- R5: The dwell between steps is `units*4` cycles. `units` is `up_dwell` or `dn_dwell` for the active direction; 0 counts as 1 and any value above 255 is clamped to 255.
- R6: The final step lands exactly on the terminal word (`hi_ftw` going up, `lo_ftw` going down) and never overshoots it. The number of steps is ceil(span/step).
- R7: `sweep_done` pulses high for exactly one cycle, in the same cycle that the terminal word first appears on `ftw_out`. `sweeping` is low in that cycle.
- R8: With `drop_mode` high, a falling trigger edge sets `ftw_out` to `lo_ftw` in one step and pulses `sweep_done` together with it.
- R9: A trigger edge that arrives during a sweep restarts it in the new direction from the current word, with the dwell of that direction.
- R10: Every clock, the phase accumulator adds `ftw_out`. One clock later, `sine_out` shows the table entry at the top 6 phase bits, as a signed value. For index i < 32 with x = i, the entry is floor(4·x·(32−x)·511/1024). For index i ≥ 32, x = i−32 and the entry is the negative of that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesis clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_en | input | 1 | Allows sweeps; when low, holds the lower word |
| trig_in | input | 1 | Asynchronous trigger; its edge polarity picks the direction |
| drop_mode | input | 1 | 1 = downward move returns in a single step |
| lo_ftw | input | 32 | Lower (start) tuning word |
| hi_ftw | input | 32 | Upper (end) tuning word |
| up_step | input | 32 | Increment per upward step |
| dn_step | input | 32 | Decrement per downward step |
| up_dwell | input | 10 | Upward dwell in 4-cycle units (clamped) |
| dn_dwell | input | 10 | Downward dwell in 4-cycle units (clamped) |
| ftw_out | output | 32 | Registered tuning word |
| sweeping | output | 1 | A stepped sweep is in progress |
| sweep_done | output | 1 | One-cycle pulse when the terminal word is reached |
| sine_out | output | 10 | Signed sine sample from the oscillator |

## Verification
The assertions rely on three things about the inputs. `lo_ftw` must not exceed `hi_ftw`. Both step sizes must be non-zero. The four word inputs may change only while `sweep_en` is low, so the ports always match the values the block latched when the sweep started. The stimulus keeps to these limits: it disables the block before it draws new random words, draws step sizes from one upward, and builds `hi_ftw` by adding a positive span to `lo_ftw`.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} sweep_dir_e;
endpackage

// File: rtl/chirp_trig_sync.sv
module chirp_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_ev = sync_q[STAGES-1] & ~last_q;
  assign fall_ev = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/chirp_dwell_timer.sv
module chirp_dwell_timer #(
  parameter int REQ_W     = 10,
  parameter int MAX_UNITS = 255,
  parameter int UNIT      = 4,
  parameter int CYC_W     = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             start_up,
  input  logic [REQ_W-1:0] up_units,
  input  logic [REQ_W-1:0] dn_units,
  output logic             tick
);
  logic [CYC_W-1:0] dwell_q, cnt_q, sel_cyc;

  // Clamp a unit request into [1, MAX_UNITS] and scale to cycles.
  function automatic logic [CYC_W-1:0] to_cycles(input logic [REQ_W-1:0] req);
    int u;
    u = int'(req);
    if (u == 0) u = 1;
    else if (u > MAX_UNITS) u = MAX_UNITS;
    return CYC_W'(u * UNIT);
  endfunction

  assign sel_cyc = start_up ? to_cycles(up_units) : to_cycles(dn_units);
  assign tick    = run && !start && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dwell_q <= CYC_W'(UNIT);
      cnt_q   <= '0;
    end else if (start) begin
      dwell_q <= sel_cyc;
      cnt_q   <= sel_cyc - 1'b1;
    end else if (tick) begin
      cnt_q   <= dwell_q - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/chirp_ramp_core.sv
module chirp_ramp_core
  import chirp_pkg::*;
#(
  parameter int FTW_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             tick,
  input  logic             drop_mode,
  input  logic [FTW_W-1:0] lo_in,
  input  logic [FTW_W-1:0] hi_in,
  input  logic [FTW_W-1:0] up_step_in,
  input  logic [FTW_W-1:0] dn_step_in,
  output logic [FTW_W-1:0] ftw,
  output logic             running,
  output logic             done
);
  logic [FTW_W-1:0] lo_q, hi_q, ustep_q, dstep_q, ftw_q;
  logic             run_q, done_q;
  sweep_dir_e       dir_q;
  logic             up_last, dn_last;

  // Final step when the remaining span fits inside one step.
  assign up_last = (ftw_q >= hi_q) || ((hi_q - ftw_q) <= ustep_q);
  assign dn_last = (ftw_q <= lo_q) || ((ftw_q - lo_q) <= dstep_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
      dir_q   <= DIR_UP;
      lo_q    <= '0;
      hi_q    <= '0;
      ustep_q <= '0;
      dstep_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        ftw_q <= lo_in;
        run_q <= 1'b0;
      end else if (rise_ev || fall_ev) begin
        lo_q    <= lo_in;
        hi_q    <= hi_in;
        ustep_q <= up_step_in;
        dstep_q <= dn_step_in;
        if (rise_ev) begin
          dir_q <= DIR_UP;
          run_q <= 1'b1;
          if (!run_q) ftw_q <= lo_in;
        end else begin
          dir_q <= DIR_DN;
          if (drop_mode) begin
            ftw_q  <= lo_in;
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            run_q <= 1'b1;
          end
        end
      end else if (run_q && tick) begin
        if (dir_q == DIR_UP) begin
          if (up_last) begin
            ftw_q  <= hi_q;
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ftw_q <= ftw_q + ustep_q;
          end
        end else begin
          if (dn_last) begin
            ftw_q  <= lo_q;
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            ftw_q <= ftw_q - dstep_q;
          end
        end
      end
    end
  end

  assign ftw     = ftw_q;
  assign running = run_q;
  assign done    = done_q;
endmodule

// File: rtl/chirp_sine_osc.sv
module chirp_sine_osc #(
  parameter int FTW_W  = 32,
  parameter int LUT_AW = 6,
  parameter int AMP_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [FTW_W-1:0]        ftw,
  output logic signed [AMP_W-1:0] sample
);
  localparam int  DEPTH = 1 << LUT_AW;
  localparam int  HALF  = DEPTH / 2;
  localparam longint PEAK = (longint'(1) << (AMP_W - 1)) - 1;

  // Parabolic half-wave approximation, negated for the second half.
  function automatic logic signed [AMP_W-1:0] wave_pt(input int idx);
    longint x, mag;
    x   = longint'(idx % HALF);
    mag = (4 * x * (HALF - x) * PEAK) / (longint'(HALF) * HALF);
    return (idx < HALF) ? AMP_W'(mag) : AMP_W'(-mag);
  endfunction

  logic signed [AMP_W-1:0] rom [DEPTH];
  logic [FTW_W-1:0]        acc_q;
  logic signed [AMP_W-1:0] sample_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = wave_pt(g);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      sample_q <= '0;
    end else begin
      acc_q    <= acc_q + ftw;
      sample_q <= rom[acc_q[FTW_W-1 -: LUT_AW]];
    end
  end

  assign sample = sample_q;
endmodule

// File: rtl/chirp_sweeper.sv
module chirp_sweeper
  import chirp_pkg::*;
#(
  parameter int FTW_W       = 32,
  parameter int DWELL_REQ_W = 10,
  parameter int DWELL_MAX   = 255,
  parameter int DWELL_UNIT  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LUT_AW      = 6,
  parameter int AMP_W       = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sweep_en,
  input  logic                   trig_in,
  input  logic                   drop_mode,
  input  logic [FTW_W-1:0]       lo_ftw,
  input  logic [FTW_W-1:0]       hi_ftw,
  input  logic [FTW_W-1:0]       up_step,
  input  logic [FTW_W-1:0]       dn_step,
  input  logic [DWELL_REQ_W-1:0] up_dwell,
  input  logic [DWELL_REQ_W-1:0] dn_dwell,
  output logic [FTW_W-1:0]       ftw_out,
  output logic                   sweeping,
  output logic                   sweep_done,
  output logic [AMP_W-1:0]       sine_out
);
  localparam int CYC_W = $clog2(DWELL_MAX * DWELL_UNIT + 1);

  logic rise_ev, fall_ev, tick, start;
  logic [FTW_W-1:0] ftw_w;
  logic run_w, done_w;
  logic signed [AMP_W-1:0] sample_w;

  chirp_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(trig_in),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  assign start = sweep_en && (rise_ev || fall_ev);

  chirp_dwell_timer #(
    .REQ_W(DWELL_REQ_W), .MAX_UNITS(DWELL_MAX), .UNIT(DWELL_UNIT), .CYC_W(CYC_W)
  ) u_timer (
    .clk(clk), .rst(rst), .run(run_w), .start(start), .start_up(rise_ev),
    .up_units(up_dwell), .dn_units(dn_dwell), .tick(tick)
  );

  chirp_ramp_core #(.FTW_W(FTW_W)) u_core (
    .clk(clk), .rst(rst), .en(sweep_en), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .tick(tick), .drop_mode(drop_mode), .lo_in(lo_ftw), .hi_in(hi_ftw),
    .up_step_in(up_step), .dn_step_in(dn_step),
    .ftw(ftw_w), .running(run_w), .done(done_w)
  );

  chirp_sine_osc #(.FTW_W(FTW_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_osc (
    .clk(clk), .rst(rst), .ftw(ftw_w), .sample(sample_w)
  );

  assign ftw_out    = ftw_w;
  assign sweeping   = run_w;
  assign sweep_done = done_w;
  assign sine_out   = sample_w;
endmodule

// File: rtl/chirp_sweeper_chk.sv
module chirp_sweeper_chk #(
  parameter int FTW_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sweep_en,
  input logic [FTW_W-1:0] lo_ftw,
  input logic [FTW_W-1:0] hi_ftw,
  input logic [FTW_W-1:0] ftw_out,
  input logic             sweeping,
  input logic             sweep_done
);
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sweep_en |=> !sweeping); // R2
  AST_OFF_HOLDS_LO: assert property (@(posedge clk) disable iff (rst)
    !sweep_en |=> ftw_out == $past(lo_ftw)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sweep_done |=> !sweep_done); // R7
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> !sweeping); // R7
  AST_DONE_AT_TERMINAL: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> (ftw_out == hi_ftw || ftw_out == lo_ftw)); // R6
  AST_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (rst)
    sweeping |-> ftw_out <= hi_ftw); // R6
endmodule

bind chirp_sweeper chirp_sweeper_chk #(.FTW_W(FTW_W)) u_chk (
  .clk(clk), .rst(rst), .sweep_en(sweep_en), .lo_ftw(lo_ftw), .hi_ftw(hi_ftw),
  .ftw_out(ftw_out), .sweeping(sweeping), .sweep_done(sweep_done)
);

// File: tb/chirp_sweeper_bench.sv
module chirp_sweeper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sweep_en = 1'b0;
  logic        trig_in = 1'b0;
  logic        drop_mode = 1'b0;
  logic [31:0] lo_ftw = '0, hi_ftw = '0, up_step = 32'd1, dn_step = 32'd1;
  logic [9:0]  up_dwell = '0, dn_dwell = '0;
  logic [31:0] ftw_out;
  logic        sweeping, sweep_done;
  logic [9:0]  sine_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit sine_on = 1'b0;

  chirp_sweeper u_chirp_sweeper (
    .clk(clk), .rst(rst), .sweep_en(sweep_en), .trig_in(trig_in),
    .drop_mode(drop_mode), .lo_ftw(lo_ftw), .hi_ftw(hi_ftw),
    .up_step(up_step), .dn_step(dn_step), .up_dwell(up_dwell),
    .dn_dwell(dn_dwell), .ftw_out(ftw_out), .sweeping(sweeping),
    .sweep_done(sweep_done), .sine_out(sine_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
      summary();
      $finish;
    end
  end

  // R10 sine model, built from the table formula in the requirement
  function automatic logic [9:0] wave(input int i);
    longint x, m;
    x = longint'(i % 32);
    m = (4 * x * (32 - x) * 511) / 1024;
    return (i < 32) ? 10'(m) : 10'(-m);
  endfunction

  logic [31:0] m_acc = '0;
  logic [9:0]  m_sine = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_acc  <= '0;
      m_sine <= '0;
    end else begin
      m_sine <= wave(int'(m_acc[31:26]));
      m_acc  <= m_acc + ftw_out;
    end
  end
  always @(negedge clk) begin
    if (sine_on && !rst)
      chk(sine_out == m_sine, "R10", "sine sample", sine_out, m_sine);
  end

  function automatic int units_of(input logic [9:0] u);
    int v;
    v = int'(u);
    if (v == 0) v = 1;
    if (v > 255) v = 255;
    return v * 4;
  endfunction

  // Follow one sweep until done; check every step value and dwell
  task automatic watch(input bit up, input logic [31:0] step, input int dcyc,
                       input logic [31:0] term, input int exp_steps, input string rq);
    logic [31:0] prev, nxt;
    int since, n;
    bit first, got;
    prev = ftw_out; since = 0; n = 0; first = 1'b1; got = 1'b0;
    for (int c = 0; c < 60000 && !got; c++) begin
      @(negedge clk);
      since++;
      if (ftw_out !== prev) begin
        if (up) nxt = (prev >= term || term - prev <= step) ? term : prev + step;
        else    nxt = (prev <= term || prev - term <= step) ? term : prev - step;
        chk(ftw_out == nxt, rq, "step value", ftw_out, nxt);
        if (!first) chk(since == dcyc, "R5", "dwell cycles", since, dcyc);
        first = 1'b0; since = 0; n++; prev = ftw_out;
      end
      if (sweep_done) begin
        got = 1'b1;
        chk(ftw_out == term, "R6", "terminal word", ftw_out, term);
        chk(!sweeping, "R7", "sweeping low at done", sweeping, 0);
      end
    end
    chk(got, "R7", "done pulse seen", got, 1);
    if (exp_steps >= 0) chk(n == exp_steps, "R6", "step count", n, exp_steps);
    @(negedge clk);
    chk(!sweep_done, "R7", "done lasts one cycle", sweep_done, 0);
  endtask

  task automatic load(input logic [31:0] lo, input logic [31:0] span,
                      input logic [31:0] us, input logic [31:0] ds,
                      input logic [9:0] ud, input logic [9:0] dd, input bit dm);
    @(negedge clk);
    sweep_en = 1'b0;
    trig_in = 1'b0;
    lo_ftw = lo; hi_ftw = lo + span; up_step = us; dn_step = ds;
    up_dwell = ud; dn_dwell = dd; drop_mode = dm;
    repeat (4) @(negedge clk);
    chk(ftw_out == lo, "R2", "disabled holds lower word", ftw_out, lo);
    sweep_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic drop_check(input logic [31:0] lo);
    int n;
    bit got;
    logic [31:0] prev;
    n = 0; got = 1'b0; prev = ftw_out;
    for (int c = 0; c < 20 && !got; c++) begin
      @(negedge clk);
      if (ftw_out !== prev) begin n++; prev = ftw_out; end
      if (sweep_done) begin
        got = 1'b1;
        chk(ftw_out == lo, "R8", "single step to lower word", ftw_out, lo);
      end
    end
    chk(got && n == 1, "R8", "one change with done", n, 1);
  endtask

  initial begin
    logic [31:0] lo, span, us, ds, cur;
    logic [9:0]  ud, dd;
    bit dm;
    void'($urandom(32'd7321));

    repeat (3) @(negedge clk);
    chk(ftw_out == 0 && !sweeping && !sweep_done && sine_out == 0, "R1",
        "reset outputs", ftw_out, 0);
    rst = 1'b0;
    sine_on = 1'b1;
    @(negedge clk);
    chk(!sweeping && !sweep_done, "R1", "idle after reset", sweeping, 0);

    // R2: triggers ignored while disabled
    lo_ftw = 32'h0012_3400;
    repeat (2) @(negedge clk);
    chk(ftw_out == 32'h0012_3400, "R2", "follows lower word", ftw_out, 32'h0012_3400);
    trig_in = 1'b1; repeat (6) @(negedge clk);
    trig_in = 1'b0; repeat (6) @(negedge clk);
    chk(ftw_out == 32'h0012_3400 && !sweeping, "R2", "trigger ignored", ftw_out, 32'h0012_3400);

    // R3/R6: directed up sweep, span not a multiple of step
    load(32'd5000, 32'd1000, 32'd300, 32'd250, 10'd2, 10'd3, 1'b0);
    trig_in = 1'b1;
    watch(1'b1, 32'd300, 8, 32'd6000, 4, "R3");
    // R4: stepped down sweep with its own step and dwell
    trig_in = 1'b0;
    watch(1'b0, 32'd250, 12, 32'd5000, 4, "R4");

    // R5: clamp above ceiling and zero units
    load(32'd100, 32'd30, 32'd10, 32'd30, 10'd700, 10'd0, 1'b0);
    trig_in = 1'b1;
    watch(1'b1, 32'd10, 1020, 32'd130, 3, "R5");
    trig_in = 1'b0;
    watch(1'b0, 32'd30, 4, 32'd100, 1, "R5");
    load(32'd100, 32'd40, 32'd10, 32'd10, 10'd0, 10'd0, 1'b0);
    trig_in = 1'b1;
    watch(1'b1, 32'd10, 4, 32'd140, 4, "R5");

    // R8: ramp up then single drop
    load(32'd2000, 32'd900, 32'd200, 32'd1, 10'd1, 10'd9, 1'b1);
    trig_in = 1'b1;
    watch(1'b1, 32'd200, 4, 32'd2900, 5, "R3");
    trig_in = 1'b0;
    drop_check(32'd2000);

    // R9: restart downward mid-sweep from current word
    load(32'd40000, 32'd10000, 32'd100, 32'd70, 10'd2, 10'd3, 1'b0);
    trig_in = 1'b1;
    repeat (40) @(negedge clk);
    chk(sweeping, "R9", "sweep in progress", sweeping, 1);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    cur = ftw_out;
    chk(sweeping && cur > 32'd40000, "R9", "still running after reversal", cur, 40001);
    watch(1'b0, 32'd70, 12, 32'd40000, int'((cur - 32'd40000 + 32'd69) / 32'd70), "R9");

    // Random sweeps (R3, R4, R6, R8)
    for (int it = 0; it < 8; it++) begin
      lo   = 32'd1000 + ($urandom % 1000000);
      span = 32'd1 + ($urandom % 50000);
      us   = span / (32'd1 + ($urandom % 30)) + ($urandom % 3);
      ds   = span / (32'd1 + ($urandom % 30)) + ($urandom % 3);
      if (us == 0) us = 1;
      if (ds == 0) ds = 1;
      ud = 10'($urandom % 13);
      dd = 10'($urandom % 13);
      dm = 1'($urandom % 2);
      load(lo, span, us, ds, ud, dd, dm);
      trig_in = 1'b1;
      watch(1'b1, us, units_of(ud), lo + span, int'((span + us - 1) / us), "R3");
      trig_in = 1'b0;
      if (dm) drop_check(lo);
      else watch(1'b0, ds, units_of(dd), lo, int'((span + ds - 1) / ds), "R4");
    end

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule